// File: doc/BRIEF.md
# Register-Transaction SPI Master with Wait-State Flow Control

This block runs a single register access over SPI. An upstream agent presents a request that gives the direction, the byte count minus one and a 24-bit register address. The block lowers chip select and shifts out a four-byte command header. It then checks the final bit that the slave returns with that header. When this bit is 0, the slave is not yet ready. The block then keeps clocking filler bytes and checks the final bit of each one until a byte ends in 1. Only after that does it move the 1 to 64 data bytes.

Write data is pulled from upstream one byte at a time through a valid/ready pair. Read data is delivered as single-cycle strobes. All bytes travel most significant bit first in SPI mode 0. A parameter sets the serial clock rate as a division of the system clock. The number of filler bytes is bounded by a parameter, and when that bound is used up the transaction ends with an error. A minimum chip-select-high interval is enforced before the next request is taken. Sequencing of several transactions is left to the agent.

Top module: `spi_xact_master`

## Requirements
- R1: Header byte 0 carries bit 7 = 1 for a read or 0 for a write, bit 6 = 1, and bits 5:0 = reqLenM1. The transfer moves reqLenM1+1 data bytes.
- R2: Header bytes 1, 2 and 3 carry reqAddr[23:16], reqAddr[15:8] and reqAddr[7:0] in that order. Every byte goes out most significant bit first.
- R3: If the MISO bit sampled on the last clock of header byte 3 is 1, the first data byte follows the header directly, with no filler bytes.
- R4: If that bit is 0, the master sends filler bytes of 0x00 one at a time. Only the final MISO bit of each filler byte is examined, and the data phase starts after the first filler byte whose final bit is 1.
- R5: CS_N falls once when a request is accepted and stays low through header, filler and data bytes. It rises once, in the cycle in which xactDone pulses.
- R6: SPI mode 0 is used. SCLK is low whenever CS_N is high, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R7: For a write, wrReady pulses exactly reqLenM1+1 times, once for each data byte. The accepted bytes are shifted out in the order they were accepted.
- R8: For a read, MOSI carries 0x00 during the data bytes. Each received byte appears on rdData with a one-cycle rdValid pulse, in order, reqLenM1+1 times.
- R9: After MAX_WAIT filler bytes that all end in 0, CS_N is released and xactDone and xactErr pulse together. No data byte is clocked, and neither wrReady nor rdValid pulses. A successful transfer ends with xactErr low.
- R10: After CS_N rises, reqReady stays low and CS_N stays high for at least CS_GAP clock cycles before the next transaction can lower it.
- R11: After reset, CS_N is high, SCLK is low, xactDone is low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle and gap elapsed; request taken when both high |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqLenM1 | input | 6 | Data byte count minus one |
| reqAddr | input | 24 | Register address |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Write byte consumed this cycle |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| xactDone | output | 1 | Transaction finished (one cycle) |
| xactErr | output | 1 | Finished by exhausting the filler-byte limit |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties hold on every cycle and are asserted continuously. These are the serial-clock rules: SCLK idles low with chip select high, and MOSI is steady while SCLK is high. The minimum chip-select-high interval is also asserted, along with the rule that chip select only falls on an accepted request and the rule that the shifter never gets a new byte while one is in flight. Other behaviour can only be shown by scenarios in which a slave model answers with chosen final bits and records MOSI byte by byte. This covers the header contents, the choice between an immediate data phase and filler bytes, the boundary at exactly MAX_WAIT filler bytes versus one more, and the order of the write and read data.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
  localparam int LEN_W  = 6;   // header field width for count-1
  localparam int ADDR_W = 24;  // three address bytes

  typedef struct packed {
    logic       startByte;     // launch one 8-bit exchange
    logic [7:0] txByte;        // byte to shift out
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_WAIT, ST_DATA, ST_GAP
  } xactState_t;
endpackage

// File: rtl/spi_xact_dp.sv
module spi_xact_dp
  import spi_xact_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rxByte,
  output logic       byteDone,
  output logic       busy
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);

  logic [DIV_W-1:0] divCnt;
  logic [7:0]       txSh, rxSh;
  logic [2:0]       bitCnt;
  logic             sclkQ, doneQ, busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; txSh <= '0; rxSh <= '0; bitCnt <= '0;
      sclkQ <= 1'b0; doneQ <= 1'b0; busyQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cmd.startByte) begin
        txSh   <= cmd.txByte;
        bitCnt <= '0;
        divCnt <= '0;
        sclkQ  <= 1'b0;
        busyQ  <= 1'b1;
      end else if (busyQ) begin
        if (divCnt == DIV_W'(HALF_DIV - 1)) begin
          divCnt <= '0;
          if (!sclkQ) begin
            sclkQ <= 1'b1;                      // rising: sample
            rxSh  <= {rxSh[6:0], miso};
          end else begin
            sclkQ <= 1'b0;                      // falling: advance
            if (bitCnt == 3'd7) begin
              busyQ <= 1'b0;
              doneQ <= 1'b1;
              txSh  <= 8'h00;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign sclk     = sclkQ;
  assign mosi     = txSh[7];
  assign rxByte   = rxSh;
  assign byteDone = doneQ;
  assign busy     = busyQ;

  AST_NO_RESTART_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startByte |-> !busyQ); // R6
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ && $past(sclkQ)) |-> $stable(mosi)); // R6
endmodule

// File: rtl/spi_xact_ctl.sv
module spi_xact_ctl
  import spi_xact_pkg::*;
#(
  parameter int MAX_WAIT = 8,
  parameter int CS_GAP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqRead,
  input  logic [LEN_W-1:0]  reqLenM1,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [7:0]        wrData,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              xactDone,
  output logic              xactErr,
  output logic              csN,
  output dpCmd_t            cmd,
  input  logic [7:0]        rxByte,
  input  logic              byteDone,
  input  logic              dpBusy
);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);
  localparam int GAP_W  = $clog2(CS_GAP + 1);

  xactState_t        state;
  logic              isRead;
  logic [LEN_W-1:0]  lenM1, dataCnt;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        hdrIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              csNQ, doneQ, errQ, rdValidQ;
  logic [7:0]        rdDataQ, hdrByte;
  logic              active, needWr;

  assign active   = (state == ST_HDR) || (state == ST_WAIT) || (state == ST_DATA);
  assign needWr   = (state == ST_DATA) && !isRead;
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    case (hdrIdx)
      2'd0:    hdrByte = {isRead, 1'b1, lenM1};
      2'd1:    hdrByte = addrQ[23:16];
      2'd2:    hdrByte = addrQ[15:8];
      default: hdrByte = addrQ[7:0];
    endcase
    cmd.startByte = active && !dpBusy && !byteDone && (!needWr || wrValid);
    cmd.txByte    = (state == ST_HDR) ? hdrByte : (needWr ? wrData : 8'h00);
  end
  assign wrReady = cmd.startByte && needWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; isRead <= 1'b0; lenM1 <= '0; addrQ <= '0;
      hdrIdx <= '0; waitCnt <= '0; dataCnt <= '0; gapCnt <= '0;
      csNQ <= 1'b1; doneQ <= 1'b0; errQ <= 1'b0;
      rdValidQ <= 1'b0; rdDataQ <= '0;
    end else begin
      doneQ <= 1'b0; errQ <= 1'b0; rdValidQ <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          isRead <= reqRead; lenM1 <= reqLenM1; addrQ <= reqAddr;
          hdrIdx <= '0; csNQ <= 1'b0; state <= ST_HDR;
        end
        ST_HDR: if (byteDone) begin
          if (hdrIdx != 2'd3) hdrIdx <= hdrIdx + 2'd1;
          else if (rxByte[0]) begin state <= ST_DATA; dataCnt <= '0; end
          else begin state <= ST_WAIT; waitCnt <= '0; end
        end
        ST_WAIT: if (byteDone) begin
          if (rxByte[0]) begin
            state <= ST_DATA; dataCnt <= '0;
          end else if (waitCnt == WAIT_W'(MAX_WAIT - 1)) begin
            csNQ <= 1'b1; doneQ <= 1'b1; errQ <= 1'b1;
            state <= ST_GAP; gapCnt <= '0;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        ST_DATA: if (byteDone) begin
          if (isRead) begin rdValidQ <= 1'b1; rdDataQ <= rxByte; end
          if (dataCnt == lenM1) begin
            csNQ <= 1'b1; doneQ <= 1'b1;
            state <= ST_GAP; gapCnt <= '0;
          end else begin
            dataCnt <= dataCnt + LEN_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(CS_GAP - 1)) state <= ST_IDLE;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN      = csNQ;
  assign xactDone = doneQ;
  assign xactErr  = errQ;
  assign rdValid  = rdValidQ;
  assign rdData   = rdDataQ;

  // checker: cycles chip select has been high, saturating at CS_GAP
  logic [GAP_W-1:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         hiCnt <= GAP_W'(CS_GAP);
    else if (!csNQ)                    hiCnt <= '0;
    else if (hiCnt != GAP_W'(CS_GAP))  hiCnt <= hiCnt + GAP_W'(1);
  end

  AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csNQ) |-> (hiCnt == GAP_W'(CS_GAP))); // R10
  AST_CS_FALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csNQ) |-> $past(reqValid && reqReady)); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    xactErr |-> (xactDone && !rdValid)); // R9
endmodule

// File: rtl/spi_xact_master.sv
module spi_xact_master
  import spi_xact_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MAX_WAIT = 8,
  parameter int CS_GAP   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqRead,
  input  logic [5:0]  reqLenM1,
  input  logic [23:0] reqAddr,
  input  logic        wrValid,
  output logic        wrReady,
  input  logic [7:0]  wrData,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        xactDone,
  output logic        xactErr,
  output logic        sclk,
  output logic        csN,
  output logic        mosi,
  input  logic        miso
);
  dpCmd_t     cmd;
  logic [7:0] rxByte;
  logic       byteDone, dpBusy;

  spi_xact_ctl #(.MAX_WAIT(MAX_WAIT), .CS_GAP(CS_GAP)) u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqRead(reqRead),
    .reqLenM1(reqLenM1), .reqAddr(reqAddr),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData),
    .xactDone(xactDone), .xactErr(xactErr), .csN(csN),
    .cmd(cmd), .rxByte(rxByte), .byteDone(byteDone), .dpBusy(dpBusy)
  );

  spi_xact_dp #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxByte(rxByte),
    .byteDone(byteDone), .busy(dpBusy)
  );

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R6
endmodule

// File: tb/spi_xact_master_tb.sv
`timescale 1ns/1ps
module spi_xact_master_tb;
  localparam int HALF_DIV = 2;
  localparam int MAX_WAIT = 8;
  localparam int CS_GAP   = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0, wrValid = 1'b1;
  logic [5:0] reqLenM1 = '0;
  logic [23:0] reqAddr = '0;
  logic [7:0] wrData, rdData;
  logic reqReady, wrReady, rdValid, xactDone, xactErr, sclk, csN, mosi, miso;

  always #2.5 clk = ~clk;

  spi_xact_master #(.HALF_DIV(HALF_DIV), .MAX_WAIT(MAX_WAIT), .CS_GAP(CS_GAP)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRead(reqRead), .reqLenM1(reqLenM1), .reqAddr(reqAddr),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .xactDone(xactDone), .xactErr(xactErr),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  int nChecks = 0, nFails = 0;
  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: records MOSI bytes, answers MISO by byte index
  int slvStall = 0;
  logic [7:0] slvSeed = '0;
  logic [7:0] rec [0:127];
  int recCnt = 0;
  logic [2:0] bitIdx = '0;
  logic [7:0] curOut = '0, rxSh = '0;

  function automatic logic [7:0] misoFor(input int idx);
    int k;
    if (idx < 3) return 8'h5A;                       // final bit 0: ignored
    if (idx == 3) return {7'h15, slvStall == 0};
    k = idx - 4;
    if (k < slvStall) return (k == slvStall - 1) ? 8'h81 : 8'h80;
    return slvSeed + 8'((k - slvStall) * 5);
  endfunction

  always @(posedge sclk or negedge csN) begin
    if (!sclk) begin
      bitIdx = '0; recCnt = 0; curOut = misoFor(0);
    end else begin
      rxSh = {rxSh[6:0], mosi};
      if (bitIdx == 3'd7) begin
        if (recCnt < 128) rec[recCnt] = rxSh;
        recCnt++;
        bitIdx = '0;
        curOut = misoFor(recCnt);
      end else bitIdx = bitIdx + 3'd1;
    end
  end
  assign miso = curOut[3'd7 - bitIdx];

  // upstream data side
  logic [7:0] wrSeed = '0;
  int wrIdx = 0, rdCnt = 0, hiRun = 0, lastHi = 0;
  logic [7:0] rdBuf [0:63];
  logic doneSeen = 1'b0, errSeen = 1'b0;
  assign wrData = wrSeed + 8'(wrIdx * 5);

  always @(posedge clk) begin
    if (reqValid) begin wrIdx <= 0; rdCnt <= 0; doneSeen <= 1'b0; errSeen <= 1'b0; end
    else begin
      if (wrReady) wrIdx <= wrIdx + 1;
      if (rdValid) begin
        if (rdCnt < 64) rdBuf[rdCnt] <= rdData;
        rdCnt <= rdCnt + 1;
      end
      if (xactDone) begin doneSeen <= 1'b1; errSeen <= xactErr; end
    end
    if (csN) hiRun <= hiRun + 1;
    else begin
      if (hiRun != 0) lastHi <= hiRun;
      hiRun <= 0;
    end
  end

  task automatic runXact(input logic rd, input logic [5:0] lm1, input logic [23:0] ad,
                         input int stall, input logic [7:0] seed);
    int t, nb, nWait, expBytes;
    bit expErr;
    logic [7:0] exp;
    slvStall = stall; slvSeed = seed; wrSeed = seed;
    t = 0;
    while (!reqReady && t < 1000) begin @(negedge clk); t++; end
    reqRead = rd; reqLenM1 = lm1; reqAddr = ad; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!doneSeen && t < 20000) begin @(negedge clk); t++; end
    expErr   = stall > MAX_WAIT;
    nb       = int'(lm1) + 1;
    nWait    = expErr ? MAX_WAIT : stall;
    expBytes = expErr ? 4 + MAX_WAIT : 4 + stall + nb;
    chk("R5 done pulse seen", doneSeen, 1);
    chk("R5 CS_N high at end", csN, 1);
    chk("R6 SCLK low at end", sclk, 0);
    if (CS_GAP > 1) chk("R10 reqReady low in gap", reqReady, 0);
    chk("R9 error flag", errSeen, expErr);
    chk(stall == 0 ? "R3 bytes under CS_N" : "R4 bytes under CS_N", recCnt, expBytes);
    chk("R10 CS_N high before start", lastHi >= CS_GAP, 1);
    chk("R1 header byte 0", rec[0], {rd, 1'b1, lm1});
    chk("R2 address high", rec[1], ad[23:16]);
    chk("R2 address mid", rec[2], ad[15:8]);
    chk("R2 address low", rec[3], ad[7:0]);
    for (int i = 0; i < nWait; i++) chk("R4 filler byte zero", rec[4 + i], 8'h00);
    if (expErr) begin
      chk("R9 no write pulls", wrIdx, 0);
      chk("R9 no read strobes", rdCnt, 0);
    end else if (rd) begin
      chk("R8 read strobes", rdCnt, nb);
      for (int i = 0; i < nb; i++) begin
        exp = seed + 8'(i * 5);
        chk("R8 read data", rdBuf[i], exp);
        chk("R8 MOSI zero in read", rec[4 + stall + i], 8'h00);
      end
    end else begin
      chk("R7 write pulls", wrIdx, nb);
      for (int i = 0; i < nb; i++) begin
        exp = seed + 8'(i * 5);
        chk("R7 write byte on MOSI", rec[4 + stall + i], exp);
      end
    end
  endtask

  // {read, lenM1, addr, stall, seed}
  localparam logic [42:0] VEC [0:5] = '{
    {1'b1, 6'd3,  24'hD40018, 4'd0, 8'h11},
    {1'b0, 6'd3,  24'hD40024, 4'd0, 8'h40},
    {1'b1, 6'd0,  24'h000F00, 4'd3, 8'h77},
    {1'b0, 6'd63, 24'h123456, 4'd1, 8'h09},
    {1'b1, 6'd63, 24'hABCDEF, 4'd8, 8'hC3},
    {1'b0, 6'd0,  24'hFFFFFF, 4'd2, 8'h20}
  };

  bit finished = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 CS_N in reset", csN, 1);
    chk("R11 SCLK in reset", sclk, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 CS_N after reset", csN, 1);
    chk("R11 SCLK after reset", sclk, 0);
    chk("R11 done low after reset", xactDone, 0);
    chk("R11 reqReady after reset", reqReady, 1);
    for (int v = 0; v < 6; v++)
      runXact(VEC[v][42], VEC[v][41:36], VEC[v][35:12], int'(VEC[v][11:8]), VEC[v][7:0]);
    // R9: one filler byte beyond the limit, read and write
    runXact(1'b1, 6'd2, 24'h0A0B0C, MAX_WAIT + 1, 8'h31);
    runXact(1'b0, 6'd5, 24'h405060, MAX_WAIT + 4, 8'h52);
    // recovery after a timeout
    runXact(1'b0, 6'd1, 24'h00FF00, 0, 8'hE0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule